// File: doc/BRIEF.md
# Cascadable LCD Column Data-Latch Controller

This block is the digital core of one segment-driver chip in a daisy chain that feeds the columns of an LCD. Pixel data arrives on a slow data clock. It is written into a data latch of 120 positions, but only while the chip holds the chain's selection. Selection is granted when the incoming enable is low after a line pulse. It is given up once all 120 positions have been written. At that point a one-data-clock low pulse on the outgoing enable passes selection to the next chip.

A falling edge of the line pulse copies the whole data latch into a line latch. Each column output then carries a 2-bit drive-level code, chosen from its line-latch bit and a frame-inversion input. A blanking input forces every column to ground and empties the line latch. Data shifting carries on while the outputs are blanked.

Data can be taken one bit per data clock (serial) or four bits per data clock (parallel). A direction input sets the fill order and decides which of the two enable pins is the input and which is the output. The data clock and the line pulse are slow strobes, sampled on the system clock `clk_i`. All actions happen on their detected falling edges.

Top module: `lcdcol_driver`

## Requirements
- R1: After reset the line latch and data latch hold zeros, both enable pins drive 1, and no position is written until a line pulse has been seen.
- R2: Column code: line bit 1 with frame 0 gives 2'd0 (V0); line bit 1 with frame 1 gives 2'd3 (ground); line bit 0 with frame 0 gives 2'd1 (V2); line bit 0 with frame 1 gives 2'd2 (V3). Column k uses bits [2k+1:2k] of `level_o`.
- R3: With `par_i`=0, each data-clock fall that finds the chip selected writes `data_i[0]`. With `dir_i`=0 it goes to position n, where n is the number of bits already taken since the line pulse. With `dir_i`=1 it goes to position 119-n.
- R4: With `par_i`=1, each selected data-clock fall writes `data_i[k]` for k=0..3. With `dir_i`=0 these go to positions n+k. With `dir_i`=1 they go to positions 119-n-k. A line then needs 30 data clocks.
- R5: Data-clock falls write nothing unless a line-pulse fall has occurred and the enable input is low at the first written fall.
- R6: Once 120 bits have been taken, later data-clock falls write nothing until the next line-pulse fall.
- R7: The enable output goes low at the data-clock fall that takes the 120th bit. It returns high at the next data-clock fall, or at a line-pulse fall. It is high at all other times.
- R8: With `dir_i`=0, enable pin 0 is the output (`en_pin_oe_o`=2'b01) and pin 1 is the input. With `dir_i`=1 the roles swap (`en_pin_oe_o`=2'b10). A pin that is not the output drives 1.
- R9: A line-pulse fall copies the data latch into the line latch. It also clears the bit count and the selection.
- R10: While `blank_ni` is low, every column code is 2'd3 and the line latch is cleared. The data latch still takes data.
- R11: After `blank_ni` rises, columns show the non-select codes (2'd1 or 2'd2, following the frame input) until the next line-pulse fall loads data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dclk_i | input | 1 | Data clock strobe; falling edge takes data |
| lp_i | input | 1 | Line pulse; falling edge latches a line |
| dir_i | input | 1 | Fill direction and enable-pin role select |
| par_i | input | 1 | 1: 4-bit parallel input, 0: serial input |
| data_i | input | 4 | Pixel data; serial mode uses bit 0 |
| frame_inv_i | input | 1 | Frame inversion |
| blank_ni | input | 1 | Low forces columns to ground and clears the line latch |
| en_pin_i | input | 2 | Values seen on the two enable pins |
| en_pin_o | output | 2 | Values driven on the two enable pins |
| en_pin_oe_o | output | 2 | Output enables of the two enable pins |
| level_o | output | 240 | 2-bit drive-level code per column |

## Verification
The assertions take the following for granted:
- Every level of `dclk_i` and `lp_i` lasts at least one system clock.
- A data-clock fall never lands in the same cycle as a line-pulse fall.
- `par_i` and `dir_i` do not change inside a line.
- `data_i` is stable at the data-clock fall.

The bench changes every input only on the falling system-clock edge. It holds each strobe level for a full system cycle and issues line pulses only between data-clock pulses. It changes mode and direction only just before a line pulse.

// File: rtl/lcdcol_pkg.sv
`timescale 1ns/1ps
package lcdcol_pkg;

  typedef enum logic [1:0] {
    LVL_V0  = 2'd0,
    LVL_V2  = 2'd1,
    LVL_V3  = 2'd2,
    LVL_GND = 2'd3
  } drive_lvl_e;

  function automatic drive_lvl_e lvl_sel(logic b, logic fr, logic blank_n);
    if (!blank_n)  return LVL_GND;
    if (b)         return fr ? LVL_GND : LVL_V0;
    return fr ? LVL_V3 : LVL_V2;
  endfunction

endpackage

// File: rtl/lcdcol_cascade.sv
`timescale 1ns/1ps
module lcdcol_cascade #(
  parameter int N     = 120,
  parameter int PAR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dclk_fall_i,
  input  logic                     lp_fall_i,
  input  logic                     dir_i,
  input  logic                     par_i,
  input  logic [1:0]               en_pin_i,
  output logic                     wr_en_o,
  output logic [$clog2(N+1)-1:0]   base_o,
  output logic [1:0]               en_pin_o,
  output logic [1:0]               en_pin_oe_o
);
  localparam int CW = $clog2(N+1);

  logic [CW-1:0] cnt_q;
  logic          sel_q, armed_q, en_out_q;
  logic          en_in_w, active_w, last_w, fin_w;
  logic [CW:0]   step_w, nxt_w;

  assign en_in_w  = dir_i ? en_pin_i[0] : en_pin_i[1];
  assign active_w = sel_q | (armed_q & ~en_in_w);
  assign step_w   = par_i ? (CW+1)'(PAR_W) : (CW+1)'(1);
  assign nxt_w    = {1'b0, cnt_q} + step_w;
  assign last_w   = nxt_w >= (CW+1)'(N);
  assign wr_en_o  = dclk_fall_i & active_w & ~lp_fall_i;
  assign fin_w    = wr_en_o & last_w;
  assign base_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sel_q    <= 1'b0;
      armed_q  <= 1'b0;
      en_out_q <= 1'b1;
    end else if (lp_fall_i) begin
      cnt_q    <= '0;
      sel_q    <= 1'b0;
      armed_q  <= 1'b1;
      en_out_q <= 1'b1;
    end else if (dclk_fall_i) begin
      if (!en_out_q) en_out_q <= 1'b1;
      if (active_w) begin
        if (last_w) begin
          sel_q    <= 1'b0;
          armed_q  <= 1'b0;
          en_out_q <= 1'b0;
        end else begin
          cnt_q <= nxt_w[CW-1:0];
          sel_q <= 1'b1;
        end
      end
    end
  end

  // role swap follows direction; idle pin drives high
  assign en_pin_oe_o = dir_i ? 2'b10 : 2'b01;
  assign en_pin_o    = dir_i ? {en_out_q, 1'b1} : {1'b1, en_out_q};

  // R7
  en_low_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_out_q && dclk_fall_i) |=> en_out_q);
  // R7
  en_fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_out_q) |-> $past(fin_w));
  // R6
  fin_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_w |=> (!sel_q && !armed_q));

endmodule

// File: rtl/lcdcol_data_latch.sv
`timescale 1ns/1ps
module lcdcol_data_latch #(
  parameter int N     = 120,
  parameter int PAR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(N+1)-1:0]   base_i,
  input  logic                     dir_i,
  input  logic                     par_i,
  input  logic [PAR_W-1:0]         data_i,
  output logic [N-1:0]             data_o
);
  localparam int CW = $clog2(N+1);
  localparam int OW = CW + 2;
  localparam int SW = $clog2(PAR_W);

  logic [OW-1:0] step_w;
  assign step_w = par_i ? OW'(PAR_W) : OW'(1);

  for (genvar g = 0; g < N; g++) begin : g_pos
    logic [OW-1:0] off;
    logic          hit;
    // offset of this position within the current write group; MSB set = behind
    assign off = (dir_i ? OW'(N-1-g) : OW'(g)) - {2'b00, base_i};
    assign hit = wr_en_i && !off[OW-1] && (off < step_w);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  data_o[g] <= 1'b0;
      else if (hit) data_o[g] <= data_i[off[SW-1:0]];
    end
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(data_o));

endmodule

// File: rtl/lcdcol_line_latch.sv
`timescale 1ns/1ps
module lcdcol_line_latch
  import lcdcol_pkg::*;
#(
  parameter int N = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_fall_i,
  input  logic             blank_ni,
  input  logic             frame_inv_i,
  input  logic [N-1:0]     data_i,
  output logic [2*N-1:0]   level_o
);
  logic [N-1:0] line_q;

  // cleared latch doubles as the non-select hold after blanking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        line_q <= '0;
    else if (!blank_ni) line_q <= '0;
    else if (lp_fall_i) line_q <= data_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_col
    assign level_o[2*g +: 2] = lvl_sel(line_q[g], frame_inv_i, blank_ni);
  end

  // R10
  blank_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> (line_q == '0));
  // R9
  line_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_fall_i && blank_ni) |=> (line_q == $past(data_i)));

endmodule

// File: rtl/lcdcol_driver.sv
`timescale 1ns/1ps
module lcdcol_driver #(
  parameter int N     = 120,
  parameter int PAR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dclk_i,
  input  logic               lp_i,
  input  logic               dir_i,
  input  logic               par_i,
  input  logic [PAR_W-1:0]   data_i,
  input  logic               frame_inv_i,
  input  logic               blank_ni,
  input  logic [1:0]         en_pin_i,
  output logic [1:0]         en_pin_o,
  output logic [1:0]         en_pin_oe_o,
  output logic [2*N-1:0]     level_o
);
  localparam int CW = $clog2(N+1);

  logic          dclk_q, lp_q;
  logic          dclk_fall, lp_fall, wr_en;
  logic [CW-1:0] base;
  logic [N-1:0]  data_lat;

  // strobes reset low so a low input at start is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_q <= 1'b0;
      lp_q   <= 1'b0;
    end else begin
      dclk_q <= dclk_i;
      lp_q   <= lp_i;
    end
  end

  assign dclk_fall = dclk_q & ~dclk_i;
  assign lp_fall   = lp_q & ~lp_i;

  lcdcol_cascade #(.N(N), .PAR_W(PAR_W)) cascade_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dclk_fall_i (dclk_fall),
    .lp_fall_i   (lp_fall),
    .dir_i       (dir_i),
    .par_i       (par_i),
    .en_pin_i    (en_pin_i),
    .wr_en_o     (wr_en),
    .base_o      (base),
    .en_pin_o    (en_pin_o),
    .en_pin_oe_o (en_pin_oe_o)
  );

  lcdcol_data_latch #(.N(N), .PAR_W(PAR_W)) data_latch_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .base_i  (base),
    .dir_i   (dir_i),
    .par_i   (par_i),
    .data_i  (data_i),
    .data_o  (data_lat)
  );

  lcdcol_line_latch #(.N(N)) line_latch_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lp_fall_i   (lp_fall),
    .blank_ni    (blank_ni),
    .frame_inv_i (frame_inv_i),
    .data_i      (data_lat),
    .level_o     (level_o)
  );

endmodule

// File: tb/lcdcol_driver_tb_top.sv
`timescale 1ns/1ps
module lcdcol_driver_tb_top;
  localparam int N  = 120;
  localparam int PW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n, dclk, lp, dir, par, fr, blank_n;
  logic [PW-1:0]   data;
  logic [1:0]      pin_i, pin_o, pin_oe;
  logic [2*N-1:0]  level;

  lcdcol_driver #(.N(N), .PAR_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dclk_i(dclk), .lp_i(lp), .dir_i(dir),
    .par_i(par), .data_i(data), .frame_inv_i(fr), .blank_ni(blank_n),
    .en_pin_i(pin_i), .en_pin_o(pin_o), .en_pin_oe_o(pin_oe), .level_o(level)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference
  int dl[N], ll[N];
  int m_cnt;
  bit m_sel, m_arm, m_en, m_pd, m_plp;

  function automatic int exp_lvl(int b, bit f, bit bn);
    if (!bn) return 3;
    if (b != 0) return f ? 3 : 0;
    return f ? 2 : 1;
  endfunction

  task automatic chk(string req, string what, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit df, lf, en_in, act;
    int step;
    df    = m_pd && !dclk;
    lf    = m_plp && !lp;
    en_in = dir ? pin_i[0] : pin_i[1];
    act   = m_sel || (m_arm && !en_in);
    step  = par ? PW : 1;
    for (int i = 0; i < N; i++) begin
      if (!blank_n) ll[i] = 0;
      else if (lf)  ll[i] = dl[i];
    end
    if (lf) begin
      m_cnt = 0; m_sel = 0; m_arm = 1; m_en = 1;
    end else if (df) begin
      if (!m_en) m_en = 1;
      if (act) begin
        for (int k = 0; k < step; k++) begin
          int pos;
          pos = dir ? (N - 1 - (m_cnt + k)) : (m_cnt + k);
          if (pos >= 0 && pos < N) dl[pos] = int'(data[k]);
        end
        m_cnt += step;
        if (m_cnt >= N) begin
          m_sel = 0; m_arm = 0; m_en = 0;
        end else m_sel = 1;
      end
    end
    m_pd  = dclk;
    m_plp = lp;
  endtask

  task automatic compare();
    logic [2*N-1:0] ev;
    logic [1:0] eo, eoe;
    for (int i = 0; i < N; i++) ev[2*i +: 2] = 2'(exp_lvl(ll[i], fr, blank_n));
    eoe = dir ? 2'b10 : 2'b01;
    eo  = dir ? {m_en, 1'b1} : {1'b1, m_en};
    chk(cur_req, "column levels", level, ev);
    chk(cur_req, "enable pins", {236'd0, pin_oe, pin_o}, {236'd0, eoe, eo});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin dl[i] = 0; ll[i] = 0; end
      m_cnt = 0; m_sel = 0; m_arm = 0; m_en = 1; m_pd = 0; m_plp = 0;
    end else model_step();
    #2;
    if (rst_n && !done) compare();
  end

  task automatic dclk_pulse(logic [PW-1:0] d);
    data = d; dclk = 1'b1;
    @(negedge clk);
    dclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic line_pulse();
    lp = 1'b1;
    @(negedge clk);
    lp = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      finish_run();
    end
  end

  initial begin
    logic first_bit;
    logic [PW-1:0] first_nib;
    dclk = 0; lp = 0; dir = 0; par = 0; data = '0; fr = 0; blank_n = 1;
    pin_i = 2'b11; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "levels after reset", level, {N{2'b01}});
    chk("R1", "enable out after reset", {238'd0, pin_o}, {238'd0, 2'b11});
    chk("R1", "enable oe after reset", {238'd0, pin_oe}, {238'd0, 2'b01});

    // R5 no writes before a line pulse, nor with enable input high
    cur_req = "R5";
    pin_i = 2'b01;
    repeat (5) dclk_pulse(4'hF);
    line_pulse();
    chk("R5", "levels, no line pulse yet", level, {N{2'b01}});
    pin_i = 2'b11;
    repeat (5) dclk_pulse(4'hF);
    line_pulse();
    chk("R5", "levels, enable input high", level, {N{2'b01}});

    // R3 serial ascending
    cur_req = "R3";
    pin_i = 2'b01;
    line_pulse();
    first_bit = 1'b1;
    dclk_pulse({3'b000, first_bit});
    for (int i = 1; i < N; i++) dclk_pulse(PW'($urandom));
    cur_req = "R7";
    chk("R7", "enable out low after 120 bits", {239'd0, pin_o[0]}, 240'd0);
    dclk_pulse(4'h0);
    chk("R7", "enable out back high", {239'd0, pin_o[0]}, 240'd1);
    cur_req = "R6";
    repeat (6) dclk_pulse(4'hE);
    line_pulse();
    cur_req = "R3";
    @(negedge clk);
    chk("R3", "position 0 holds first serial bit", {238'd0, level[1:0]}, {238'd0, 2'd0});

    // R4 / R8 parallel descending, frame toggling (R2)
    dir = 1; par = 1; pin_i = 2'b10;
    @(negedge clk);
    chk("R8", "oe swapped for dir 1", {238'd0, pin_oe}, {238'd0, 2'b10});
    cur_req = "R2";
    line_pulse();
    first_nib = 4'b0101;
    dclk_pulse(first_nib);
    for (int i = 1; i < N/PW; i++) begin
      fr = 1'($urandom);
      dclk_pulse(PW'($urandom));
    end
    chk("R8", "enable output on pin 1 for dir 1", {238'd0, pin_o}, {238'd0, 2'b01});
    fr = 0;
    line_pulse();
    chk("R4", "position 119 holds nibble bit 0", {238'd0, level[2*N-1 -: 2]}, {238'd0, 2'd0});
    chk("R4", "position 118 holds nibble bit 1", {238'd0, level[2*N-3 -: 2]}, {238'd0, 2'd1});
    fr = 1;
    @(negedge clk);
    chk("R2", "select with frame 1 is ground", {238'd0, level[2*N-1 -: 2]}, {238'd0, 2'd3});
    fr = 0;

    // R10 / R11 blanking
    dir = 0; par = 1; pin_i = 2'b01;
    cur_req = "R10";
    line_pulse();
    repeat (10) dclk_pulse(4'hF);
    blank_n = 0;
    @(negedge clk);
    chk("R10", "all columns ground while blanked", level, {N{2'b11}});
    repeat (20) dclk_pulse(4'hF);
    line_pulse();
    chk("R10", "ground after line pulse in blank", level, {N{2'b11}});
    blank_n = 1; fr = 0;
    cur_req = "R11";
    @(negedge clk);
    chk("R11", "non-select V2 after release", level, {N{2'b01}});
    fr = 1;
    @(negedge clk);
    chk("R11", "non-select V3 after release", level, {N{2'b10}});
    fr = 0;
    line_pulse();
    chk("R11", "data shown after next line pulse", level, {N{2'b00}});

    // R9 line pulse mid-line restarts the count
    cur_req = "R9";
    dir = 1; par = 0; pin_i = 2'b10;
    line_pulse();
    for (int i = 0; i < 40; i++) dclk_pulse(PW'($urandom));
    line_pulse();
    for (int i = 0; i < N; i++) dclk_pulse(PW'($urandom));
    line_pulse();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule